// File: doc/BRIEF.md
# Dual-Mode Radix-2/4 Butterfly

This unit is the arithmetic core of a memory-based FFT engine. Every valid cycle it takes four complex samples with signed fixed-point parts. It then produces either one decimation-in-frequency radix-4 butterfly or two independent radix-2 butterflies. The results pass through a single output register. No multipliers are used: the rotations by plus or minus j are done by swapping the real and imaginary parts and negating one of them.

A 4-bit configuration code selects the mode. Bit 3 is the radix-2 flag. Bits 2:0 carry the starting stage that belongs to the configured transform size. Sizes that are odd powers of two (128, 512, 2048, 8192) set the flag for the one radix-2 pass that runs before their radix-4 passes. Each output component is two bits wider than the input, so no sum can overflow.

Top module: `fft_bfly24`

## Requirements
- R1: While rst_ni is low, and until the first valid input is captured, valid_o is 0 and every output component is 0.
- R2: valid_o equals the valid_i of the previous rising clock edge. The results for an input captured at edge k appear at edge k+1.
- R3: With cfg_i[3]=0 (radix-4), let a, b, c and d be sample lanes 0, 1, 2 and 3. Then lane 0 is (a+c)+(b+d) and lane 2 is (a+c)-(b+d).
- R4: In radix-4 mode, lane 1 is (a-c) rotated by -j on (b-d), meaning re=(a-c).re+(b-d).im and im=(a-c).im-(b-d).re. Lane 3 uses the +j rotation: re=(a-c).re-(b-d).im and im=(a-c).im+(b-d).re.
- R5: With cfg_i[3]=1 (radix-2), lane 0 is x0+x1, lane 1 is x0-x1, lane 2 is x2+x3 and lane 3 is x2-x3. Both butterflies are produced in the same cycle.
- R6: Outputs are IW+2 bits, sign-extended. Full-scale inputs, including all lanes at -2^(IW-1), give exact results with no wrap.
- R7: With each valid result, radix2_o is the captured cfg_i[3] and stage_o is the captured cfg_i[2:0].
- R8: When valid_i is low at an edge, the data outputs, radix2_o and stage_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input samples and cfg_i are valid |
| cfg_i | input | 4 | Bit 3 radix-2 flag, bits 2:0 start stage |
| x_re_i | input | 4*IW | Real parts, lane k at bits [k*IW +: IW] |
| x_im_i | input | 4*IW | Imaginary parts, same lane packing |
| valid_o | output | 1 | Output results are valid |
| radix2_o | output | 1 | Mode of the current result |
| stage_o | output | 3 | Start stage of the current result |
| y_re_o | output | 4*(IW+2) | Real results, lane k at bits [k*OW +: OW] |
| y_im_o | output | 4*(IW+2) | Imaginary results |

## Verification
Two things meet in one cycle in this block: the two radix-2 butterflies are computed together, and a change of mode between consecutive valid inputs must not leak one result into the other. The stimulus fills all four lanes with unrelated values, so a crossed pair shows up in at least one lane. It also alternates radix-2 and radix-4 codes on back-to-back cycles, with varying stage fields. A queued model checks every lane, the mode flag and the stage against the input captured one edge earlier. Idle cycles with scrambled data confirm that the outputs hold their values.

// File: rtl/fft_bfly_pkg.sv
package fft_bfly_pkg;
  localparam int CFG_W   = 4;
  localparam int STAGE_W = CFG_W - 1;
  localparam int LANES   = 4;

  typedef enum logic {
    MODE_R4 = 1'b0,
    MODE_R2 = 1'b1
  } bfly_mode_e;
endpackage

// File: rtl/bfly_cfg_decode.sv
module bfly_cfg_decode
  import fft_bfly_pkg::*;
(
  input  logic [CFG_W-1:0]   cfg_i,
  output bfly_mode_e         mode_o,
  output logic [STAGE_W-1:0] stage_o
);
  assign mode_o  = cfg_i[CFG_W-1] ? MODE_R2 : MODE_R4;
  assign stage_o = cfg_i[STAGE_W-1:0];
endmodule

// File: rtl/bfly_r2_pair.sv
module bfly_r2_pair
  import fft_bfly_pkg::*;
#(
  parameter int IW = 16,
  parameter int OW = IW + 2
) (
  input  logic [LANES-1:0][IW-1:0] x_re_i,
  input  logic [LANES-1:0][IW-1:0] x_im_i,
  output logic [LANES-1:0][OW-1:0] y_re_o,
  output logic [LANES-1:0][OW-1:0] y_im_o
);
  for (genvar g = 0; g < LANES/2; g++) begin : g_pair
    logic signed [OW-1:0] p_re, p_im, q_re, q_im;
    assign p_re = OW'($signed(x_re_i[2*g]));
    assign p_im = OW'($signed(x_im_i[2*g]));
    assign q_re = OW'($signed(x_re_i[2*g+1]));
    assign q_im = OW'($signed(x_im_i[2*g+1]));
    assign y_re_o[2*g]   = p_re + q_re;
    assign y_im_o[2*g]   = p_im + q_im;
    assign y_re_o[2*g+1] = p_re - q_re;
    assign y_im_o[2*g+1] = p_im - q_im;
  end
endmodule

// File: rtl/bfly_r4.sv
module bfly_r4
  import fft_bfly_pkg::*;
#(
  parameter int IW = 16,
  parameter int OW = IW + 2
) (
  input  logic [LANES-1:0][IW-1:0] x_re_i,
  input  logic [LANES-1:0][IW-1:0] x_im_i,
  output logic [LANES-1:0][OW-1:0] y_re_o,
  output logic [LANES-1:0][OW-1:0] y_im_o
);
  logic signed [OW-1:0] xr [LANES];
  logic signed [OW-1:0] xi [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_ext
    assign xr[k] = OW'($signed(x_re_i[k]));
    assign xi[k] = OW'($signed(x_im_i[k]));
  end

  logic signed [OW-1:0] s_ac_re, s_ac_im, s_bd_re, s_bd_im;
  logic signed [OW-1:0] d_ac_re, d_ac_im, d_bd_re, d_bd_im;

  always_comb begin
    s_ac_re = xr[0] + xr[2];
    s_ac_im = xi[0] + xi[2];
    d_ac_re = xr[0] - xr[2];
    d_ac_im = xi[0] - xi[2];
    s_bd_re = xr[1] + xr[3];
    s_bd_im = xi[1] + xi[3];
    d_bd_re = xr[1] - xr[3];
    d_bd_im = xi[1] - xi[3];
    y_re_o[0] = s_ac_re + s_bd_re;
    y_im_o[0] = s_ac_im + s_bd_im;
    y_re_o[2] = s_ac_re - s_bd_re;
    y_im_o[2] = s_ac_im - s_bd_im;
    // -j*(r,i) = (i,-r)
    y_re_o[1] = d_ac_re + d_bd_im;
    y_im_o[1] = d_ac_im - d_bd_re;
    // +j*(r,i) = (-i,r)
    y_re_o[3] = d_ac_re - d_bd_im;
    y_im_o[3] = d_ac_im + d_bd_re;
  end
endmodule

// File: rtl/fft_bfly24.sv
module fft_bfly24
  import fft_bfly_pkg::*;
#(
  parameter int IW = 16,
  localparam int OW = IW + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CFG_W-1:0]        cfg_i,
  input  logic [LANES-1:0][IW-1:0] x_re_i,
  input  logic [LANES-1:0][IW-1:0] x_im_i,
  output logic                    valid_o,
  output logic                    radix2_o,
  output logic [STAGE_W-1:0]      stage_o,
  output logic [LANES-1:0][OW-1:0] y_re_o,
  output logic [LANES-1:0][OW-1:0] y_im_o
);
  bfly_mode_e         mode;
  logic [STAGE_W-1:0] stage;
  logic [LANES-1:0][OW-1:0] r2_re, r2_im, r4_re, r4_im;
  logic [LANES-1:0][OW-1:0] sel_re, sel_im;

  bfly_cfg_decode u_dec (
    .cfg_i  (cfg_i),
    .mode_o (mode),
    .stage_o(stage)
  );

  bfly_r2_pair #(.IW(IW), .OW(OW)) u_r2 (
    .x_re_i(x_re_i), .x_im_i(x_im_i),
    .y_re_o(r2_re),  .y_im_o(r2_im)
  );

  bfly_r4 #(.IW(IW), .OW(OW)) u_r4 (
    .x_re_i(x_re_i), .x_im_i(x_im_i),
    .y_re_o(r4_re),  .y_im_o(r4_im)
  );

  assign sel_re = (mode == MODE_R2) ? r2_re : r4_re;
  assign sel_im = (mode == MODE_R2) ? r2_im : r4_im;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      radix2_o <= 1'b0;
      stage_o  <= '0;
      y_re_o   <= '0;
      y_im_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        radix2_o <= (mode == MODE_R2);
        stage_o  <= stage;
        y_re_o   <= sel_re;
        y_im_o   <= sel_im;
      end
    end
  end
endmodule

// File: rtl/fft_bfly24_chk.sv
module fft_bfly24_chk #(
  parameter int IW = 16,
  parameter int OW = IW + 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [3:0]          cfg_i,
  input logic [3:0][IW-1:0]  x_re_i,
  input logic                valid_o,
  input logic                radix2_o,
  input logic [2:0]          stage_o,
  input logic [3:0][OW-1:0]  y_re_o,
  input logic [3:0][OW-1:0]  y_im_o
);
  logic seen_q;
  logic signed [OW+1:0] ac_q, x0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ac_q   <= '0;
      x0_q   <= '0;
    end else begin
      seen_q <= 1'b1;
      ac_q   <= (OW+2)'($signed(x_re_i[0])) + (OW+2)'($signed(x_re_i[2]));
      x0_q   <= (OW+2)'($signed(x_re_i[0]));
    end
  end

  logic signed [OW+1:0] sum02, sum01;
  assign sum02 = (OW+2)'($signed(y_re_o[0])) + (OW+2)'($signed(y_re_o[2]));
  assign sum01 = (OW+2)'($signed(y_re_o[0])) + (OW+2)'($signed(y_re_o[1]));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!valid_o);
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> valid_o == $past(valid_i));

  assert_r4_even_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(valid_i) && !$past(cfg_i[3])) |-> sum02 == 2 * ac_q);

  assert_r2_pair_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(valid_i) && $past(cfg_i[3])) |-> sum01 == 2 * x0_q);

  assert_cfg_tag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(valid_i)) |-> (radix2_o == $past(cfg_i[3]) && stage_o == $past(cfg_i[2:0])));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(valid_i)) |-> ($stable(y_re_o) && $stable(y_im_o) && $stable(stage_o) && $stable(radix2_o)));
endmodule

bind fft_bfly24 fft_bfly24_chk #(.IW(IW), .OW(OW)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .cfg_i   (cfg_i),
  .x_re_i  (x_re_i),
  .valid_o (valid_o),
  .radix2_o(radix2_o),
  .stage_o (stage_o),
  .y_re_o  (y_re_o),
  .y_im_o  (y_im_o)
);

// File: tb/fft_bfly24_tb_top.sv
`timescale 1ns/1ps
module fft_bfly24_tb_top;
  localparam int IW = 16;
  localparam int OW = IW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [3:0] cfg_i = '0;
  logic [3:0][IW-1:0] x_re_i = '0, x_im_i = '0;
  logic valid_o, radix2_o;
  logic [2:0] stage_o;
  logic [3:0][OW-1:0] y_re_o, y_im_o;

  always #2 clk = ~clk;

  fft_bfly24 #(.IW(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .cfg_i(cfg_i),
    .x_re_i(x_re_i), .x_im_i(x_im_i), .valid_o(valid_o), .radix2_o(radix2_o),
    .stage_o(stage_o), .y_re_o(y_re_o), .y_im_o(y_im_o)
  );

  typedef struct {
    int re[4];
    int im[4];
    bit r2;
    int st;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 1'b0;
  int   total = 0, bad = 0;
  bit   done = 1'b0;
  bit   mon_on = 1'b0;

  function automatic int sx(logic [OW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit r2, logic [2:0] st, int xr[4], int xi[4]);
    exp_t e;
    int sr, si, tr, ti, ur, ui, vr, vi;
    @(negedge clk);
    valid_i = 1'b1;
    cfg_i   = {r2, st};
    for (int k = 0; k < 4; k++) begin
      x_re_i[k] = xr[k][IW-1:0];
      x_im_i[k] = xi[k][IW-1:0];
    end
    e.r2 = r2;
    e.st = int'(st);
    if (r2) begin
      for (int g = 0; g < 2; g++) begin
        e.re[2*g]   = xr[2*g] + xr[2*g+1];
        e.im[2*g]   = xi[2*g] + xi[2*g+1];
        e.re[2*g+1] = xr[2*g] - xr[2*g+1];
        e.im[2*g+1] = xi[2*g] - xi[2*g+1];
      end
    end else begin
      sr = xr[0] + xr[2]; si = xi[0] + xi[2];
      tr = xr[1] + xr[3]; ti = xi[1] + xi[3];
      ur = xr[0] - xr[2]; ui = xi[0] - xi[2];
      vr = xr[1] - xr[3]; vi = xi[1] - xi[3];
      e.re[0] = sr + tr; e.im[0] = si + ti;
      e.re[2] = sr - tr; e.im[2] = si - ti;
      e.re[1] = ur + vi; e.im[1] = ui - vr;
      e.re[3] = ur - vi; e.im[3] = ui + vr;
    end
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      valid_i = 1'b0;
      cfg_i   = 4'($urandom);
      x_re_i  = 64'({$urandom, $urandom});
      x_im_i  = 64'({$urandom, $urandom});
    end
  endtask

  task automatic rand_vec(output int xr[4], output int xi[4]);
    logic signed [IW-1:0] t;
    for (int k = 0; k < 4; k++) begin
      t = IW'($urandom); xr[k] = int'(t);
      t = IW'($urandom); xi[k] = int'(t);
    end
  endtask

  // monitor / scoreboard
  initial begin
    bit exp_v;
    exp_t e;
    exp_v = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (mon_on) begin
        check(valid_o == exp_v, "R2", "valid_o", int'(valid_o), int'(exp_v));
        if (valid_o) begin
          if (q.size() == 0) begin
            check(1'b0, "R2", "unexpected result, queue depth", 0, 1);
          end else begin
            e = q.pop_front();
            for (int k = 0; k < 4; k++) begin
              // R3 R4 R5 R6 lane values
              check(sx(y_re_o[k]) == e.re[k], e.r2 ? "R5" : "R3/R4", $sformatf("lane%0d re", k), sx(y_re_o[k]), e.re[k]);
              check(sx(y_im_o[k]) == e.im[k], e.r2 ? "R5" : "R3/R4", $sformatf("lane%0d im", k), sx(y_im_o[k]), e.im[k]);
            end
            check(radix2_o == e.r2, "R7", "radix2_o", int'(radix2_o), int'(e.r2));
            check(int'(stage_o) == e.st, "R7", "stage_o", int'(stage_o), e.st);
            last = e;
            have_last = 1'b1;
          end
        end else if (have_last) begin
          for (int k = 0; k < 4; k++) begin
            check(sx(y_re_o[k]) == last.re[k], "R8", $sformatf("hold lane%0d re", k), sx(y_re_o[k]), last.re[k]);
            check(sx(y_im_o[k]) == last.im[k], "R8", $sformatf("hold lane%0d im", k), sx(y_im_o[k]), last.im[k]);
          end
          check(int'(stage_o) == last.st, "R8", "hold stage_o", int'(stage_o), last.st);
        end
        exp_v = valid_i;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int xr[4], xi[4];
    repeat (3) @(posedge clk);
    #1;
    check(valid_o == 1'b0, "R1", "valid_o in reset", int'(valid_o), 0);
    check(y_re_o == '0 && y_im_o == '0, "R1", "data in reset nonzero", 1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(valid_o == 1'b0 && y_re_o == '0, "R1", "idle after reset", int'(valid_o), 0);
    mon_on = 1'b1;

    // R3 R4: simple radix-4 pattern, stage 3
    xr = '{1, 2, 3, 4}; xi = '{10, -20, 30, -40};
    drive(1'b0, 3'd3, xr, xi);
    // R5: two radix-2 butterflies, unrelated pairs, stage 1
    xr = '{100, -7, 2000, 55}; xi = '{-3, 9, -900, 1};
    drive(1'b1, 3'd1, xr, xi);
    idle(2);  // R8 hold with scrambled inputs
    // R6: full-scale negative, radix-4 and radix-2
    xr = '{-32768, -32768, -32768, -32768}; xi = '{32767, 32767, 32767, 32767};
    drive(1'b0, 3'd5, xr, xi);
    drive(1'b1, 3'd6, xr, xi);
    // R6: extremes that maximise the rotated lanes
    xr = '{32767, -32768, -32768, 32767}; xi = '{-32768, 32767, 32767, -32768};
    drive(1'b0, 3'd0, xr, xi);
    xr = '{32767, -32768, -32768, 32767}; xi = '{32767, -32768, -32768, 32767};
    drive(1'b1, 3'd7, xr, xi);
    idle(1);
    // alternating modes back to back with random data
    for (int n = 0; n < 60; n++) begin
      rand_vec(xr, xi);
      drive(n[0], 3'(n), xr, xi);
      if (n % 13 == 12) idle(1);
    end
    idle(3);
    check(q.size() == 0, "R2", "results left in queue", q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule